// File: doc/BRIEF.md
# Shift, Rotate and Single-Bit Unit

This block is the purely combinational datapath slice of an 8-bit processor that handles the shift, rotate and single-bit instruction group. The decoder presents an operation code together with the data byte, a bit index, the accumulator and the current flag byte. In the same cycle the block returns the new data byte, a second byte used only by the nibble rotations, and the updated flag byte.

The unit covers left and right shifts in their arithmetic and logical forms, a left shift that feeds in a one, 9-bit rotations through the carry, 8-bit circular rotations, the fast accumulator rotations that keep sign, zero and parity, 12-bit nibble rotations spread across the accumulator and a memory byte, and bit test, set and clear. Instruction fetch, decode and memory access sit outside the block.

The flag byte uses these bit positions: S=7, Z=6, H=4, P/V=2, N=1, C=0. Bits 5 and 3 are not owned by this unit. Parity on P/V is 1 when the byte holds an even number of ones.

Top module: `srb_unit`

## Requirements
- R1: Code 0 (shift left) gives `{d[6:0],0}` with C=d[7], and code 3 (logical shift right) gives `{0,d[7:1]}` with C=d[0].
- R2: Code 1 (arithmetic shift right) gives `{d[7],d[7:1]}` with C=d[0].
- R3: Code 2 (shift left with one) gives `{d[6:0],1}` and clears C.
- R4: Code 4 rotates left through carry, giving `{d[6:0],Cin}` with C=d[7]. Code 5 rotates right through carry, giving `{Cin,d[7:1]}` with C=d[0].
- R5: Code 6 rotates circularly left, giving `{d[6:0],d[7]}` with C=d[7]. Code 7 rotates circularly right, giving `{d[0],d[7:1]}` with C=d[0].
- R6: For codes 0 to 7, H and N are cleared. S is taken from result bit 7. Z is set when the result is zero. P/V is set when the result has even parity.
- R7: Codes 8, 9, 10 and 11 apply the rotations of codes 4, 5, 6 and 7 to the accumulator input. They set C as those codes do and clear H and N. S, Z, P/V and bits 5 and 3 keep their incoming values.
- R8: Code 12 (nibble left) maps A=aaaa_xxxx and M=yyyy_zzzz to res_o=aaaa_yyyy and res2_o=zzzz_xxxx. Code 13 (nibble right) gives res_o=aaaa_zzzz and res2_o=xxxx_yyyy. M is the data byte input.
- R9: For codes 12 and 13, C is kept and H and N are cleared. S, Z and P/V are computed from the new accumulator byte.
- R10: Code 14 (bit test) sets Z to the inverse of d[bit], sets H, clears N, S and P/V, and keeps C. res_o equals d.
- R11: Code 15 sets d[bit] and code 16 clears d[bit]. All other bits and all flags are unchanged.
- R12: Codes 17 to 31 return res_o=d with the flags unchanged. res2_o is 0 for every code except 12 and 13. Flag bits 5 and 3 always pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| opnd_i | input | 8 | Data byte (the memory byte for the nibble rotations) |
| bit_sel_i | input | 3 | Bit index for test, set and clear |
| acc_i | input | 8 | Accumulator |
| flags_i | input | 8 | Incoming flag byte |
| res_o | output | 8 | Result byte (the new accumulator for the nibble rotations) |
| res2_o | output | 8 | New memory byte for the nibble rotations, otherwise 0 |
| flags_o | output | 8 | Updated flag byte |

## Verification
Two effects land in the same evaluation in a rotation through carry: the incoming C is consumed as a data bit while the outgoing bit replaces it. In a nibble rotation, two result bytes and the flags derived from one of them change together. The bench provokes the first with operands whose outgoing bit and incoming carry differ, agree, and combine into a zero result. It provokes the second with accumulator and memory nibbles that are all distinct. A behavioural model built on integer arithmetic judges every result byte, second byte and flag byte each clock.

// File: rtl/srb_pkg.sv
`timescale 1ns/1ps
package srb_pkg;
    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int BW  = $clog2(DW);
    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_SLA  = 5'd0,
        OP_SRA  = 5'd1,
        OP_SLI  = 5'd2,
        OP_SRL  = 5'd3,
        OP_RLT  = 5'd4,
        OP_RRT  = 5'd5,
        OP_RLC  = 5'd6,
        OP_RRC  = 5'd7,
        OP_ARLT = 5'd8,
        OP_ARRT = 5'd9,
        OP_ARLC = 5'd10,
        OP_ARRC = 5'd11,
        OP_NRL  = 5'd12,
        OP_NRR  = 5'd13,
        OP_BTST = 5'd14,
        OP_BSET = 5'd15,
        OP_BCLR = 5'd16
    } op_e;

    // packed so that bit positions match the arithmetic unit's flag byte
    typedef struct packed {
        logic s;
        logic z;
        logic x5;
        logic h;
        logic x3;
        logic pv;
        logic n;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] val;
        logic          cy;
    } shres_t;

    function automatic logic even_par(input logic [DW-1:0] v);
        return ~^v;
    endfunction

    function automatic logic is_fast(input op_e o);
        return (o == OP_ARLT) || (o == OP_ARRT) || (o == OP_ARLC) || (o == OP_ARRC);
    endfunction

    function automatic op_e full_form(input op_e o);
        case (o)
            OP_ARLT: return OP_RLT;
            OP_ARRT: return OP_RRT;
            OP_ARLC: return OP_RLC;
            OP_ARRC: return OP_RRC;
            default: return o;
        endcase
    endfunction
endpackage

// File: rtl/srb_shifter.sv
`timescale 1ns/1ps
module srb_shifter
    import srb_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] din,
    input  logic          cin,
    output shres_t        out,
    output logic          hit
);
    op_e base;

    always_comb begin
        base = full_form(op);
        hit  = 1'b1;
        out  = '{val: din, cy: cin};
        case (base)
            OP_SLA: out = '{val: {din[DW-2:0], 1'b0},      cy: din[DW-1]};
            OP_SRA: out = '{val: {din[DW-1], din[DW-1:1]}, cy: din[0]};
            OP_SLI: out = '{val: {din[DW-2:0], 1'b1},      cy: 1'b0};
            OP_SRL: out = '{val: {1'b0, din[DW-1:1]},      cy: din[0]};
            OP_RLT: out = '{val: {din[DW-2:0], cin},       cy: din[DW-1]};
            OP_RRT: out = '{val: {cin, din[DW-1:1]},       cy: din[0]};
            OP_RLC: out = '{val: {din[DW-2:0], din[DW-1]}, cy: din[DW-1]};
            OP_RRC: out = '{val: {din[0], din[DW-1:1]},    cy: din[0]};
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        if (base == OP_RRC)
            p_rrc_wrap_r5: assert (out.val[DW-1] == out.cy)
                else $error("circular right: top bit differs from carry");
    end
endmodule

// File: rtl/srb_nibble.sv
`timescale 1ns/1ps
module srb_nibble
    import srb_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] mem,
    output logic [DW-1:0] acc_n,
    output logic [DW-1:0] mem_n,
    output logic          hit
);
    logic [NW-1:0] a_hi, a_lo, m_hi, m_lo;

    always_comb begin
        {a_hi, a_lo} = acc;
        {m_hi, m_lo} = mem;
        hit   = 1'b1;
        acc_n = acc;
        mem_n = '0;
        case (op)
            OP_NRL: begin
                acc_n = {a_hi, m_hi};
                mem_n = {m_lo, a_lo};
            end
            OP_NRR: begin
                acc_n = {a_hi, m_lo};
                mem_n = {a_lo, m_hi};
            end
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        if (hit)
            p_nib_high_kept_r8: assert (acc_n[DW-1:NW] == acc[DW-1:NW])
                else $error("nibble rotate changed accumulator high nibble");
    end
endmodule

// File: rtl/srb_bitop.sv
`timescale 1ns/1ps
module srb_bitop
    import srb_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] din,
    input  logic [BW-1:0] sel,
    output logic [DW-1:0] dout,
    output logic          tbit,
    output logic          hit
);
    logic [DW-1:0] mask;

    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign mask[i] = (sel == BW'(i));
    end

    always_comb begin
        tbit = |(din & mask);
        hit  = 1'b1;
        dout = din;
        case (op)
            OP_BSET: dout = din | mask;
            OP_BCLR: dout = din & ~mask;
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        if (op == OP_BSET)
            p_set_only_one_r11: assert (dout[sel] && ((dout ^ din) & ~mask) == '0)
                else $error("bit set disturbed other bits");
        if (op == OP_BCLR)
            p_clr_only_one_r11: assert (!dout[sel] && ((dout ^ din) & ~mask) == '0)
                else $error("bit clear disturbed other bits");
    end
endmodule

// File: rtl/srb_unit.sv
`timescale 1ns/1ps
module srb_unit
    import srb_pkg::*;
(
    input  logic [4:0] op_i,
    input  logic [7:0] opnd_i,
    input  logic [2:0] bit_sel_i,
    input  logic [7:0] acc_i,
    input  logic [7:0] flags_i,
    output logic [7:0] res_o,
    output logic [7:0] res2_o,
    output logic [7:0] flags_o
);
    op_e           op;
    flags_t        fin, fout;
    logic [DW-1:0] sh_src;
    shres_t        sh;
    logic          sh_hit, nb_hit, bt_hit, tbit;
    logic [DW-1:0] nb_acc, nb_mem, bt_out;

    assign op     = op_e'(op_i);
    assign fin    = flags_t'(flags_i);
    assign sh_src = is_fast(op) ? acc_i : opnd_i;

    srb_shifter u_shift (
        .op  (op),
        .din (sh_src),
        .cin (fin.c),
        .out (sh),
        .hit (sh_hit)
    );

    srb_nibble u_nib (
        .op    (op),
        .acc   (acc_i),
        .mem   (opnd_i),
        .acc_n (nb_acc),
        .mem_n (nb_mem),
        .hit   (nb_hit)
    );

    srb_bitop u_bit (
        .op   (op),
        .din  (opnd_i),
        .sel  (bit_sel_i),
        .dout (bt_out),
        .tbit (tbit),
        .hit  (bt_hit)
    );

    always_comb begin
        fout   = fin;
        res_o  = opnd_i;
        res2_o = '0;
        if (sh_hit) begin
            res_o  = sh.val;
            fout.c = sh.cy;
            fout.h = 1'b0;
            fout.n = 1'b0;
            if (!is_fast(op)) begin
                fout.s  = sh.val[DW-1];
                fout.z  = (sh.val == '0);
                fout.pv = even_par(sh.val);
            end
        end else if (nb_hit) begin
            res_o   = nb_acc;
            res2_o  = nb_mem;
            fout.s  = nb_acc[DW-1];
            fout.z  = (nb_acc == '0);
            fout.pv = even_par(nb_acc);
            fout.h  = 1'b0;
            fout.n  = 1'b0;
        end else if (op == OP_BTST) begin
            fout.z  = ~tbit;
            fout.h  = 1'b1;
            fout.n  = 1'b0;
            fout.s  = 1'b0;
            fout.pv = 1'b0;
        end else if (bt_hit) begin
            res_o = bt_out;
        end
        flags_o = fout;
    end

    always_comb begin
        if (is_fast(op))
            p_fast_keeps_szp_r7: assert (flags_o[7] == flags_i[7] && flags_o[6] == flags_i[6]
                                         && flags_o[2] == flags_i[2])
                else $error("fast rotation altered S/Z/PV");
        if (op == OP_BSET || op == OP_BCLR)
            p_bit_flags_same_r11: assert (flags_o == flags_i)
                else $error("bit set/clear altered flags");
        if (op == OP_NRL || op == OP_NRR)
            p_nib_carry_kept_r9: assert (flags_o[0] == flags_i[0])
                else $error("nibble rotate altered carry");
        if (op == OP_BTST)
            p_btest_z_r10: assert (flags_o[6] != opnd_i[bit_sel_i] && res_o == opnd_i)
                else $error("bit test Z wrong");
        if (op_i <= 5'd7)
            p_shift_hn_clear_r6: assert (!flags_o[4] && !flags_o[1])
                else $error("shift left H or N set");
        p_spare_bits_r12: assert (flags_o[5] == flags_i[5] && flags_o[3] == flags_i[3])
            else $error("spare flag bits changed");
    end
endmodule

// File: tb/tb_srb_unit.sv
`timescale 1ns/1ps
module tb_srb_unit;
    logic clk = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] opnd_i = '0, acc_i = '0, flags_i = '0;
    logic [2:0] bit_sel_i = '0;
    logic [7:0] res_o, res2_o, flags_o;
    int total = 0, bad = 0, cycles = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    srb_unit dut (
        .op_i(op_i), .opnd_i(opnd_i), .bit_sel_i(bit_sel_i), .acc_i(acc_i),
        .flags_i(flags_i), .res_o(res_o), .res2_o(res2_o), .flags_o(flags_o)
    );

    function automatic int par_even(input int v);
        int cnt = 0;
        for (int i = 0; i < 8; i++) if ((v >> i) % 2 == 1) cnt++;
        return (cnt % 2 == 0) ? 1 : 0;
    endfunction

    function automatic string rtag(input int op);
        if (op == 0 || op == 3) return "R1";
        if (op == 1) return "R2";
        if (op == 2) return "R3";
        if (op == 4 || op == 5) return "R4";
        if (op == 6 || op == 7) return "R5";
        if (op >= 8 && op <= 11) return "R7";
        if (op == 12 || op == 13) return "R8";
        if (op == 14) return "R10";
        if (op == 15 || op == 16) return "R11";
        return "R12";
    endfunction

    function automatic string ftag(input int op);
        if (op <= 7) return "R6";
        if (op <= 11) return "R7";
        if (op <= 13) return "R9";
        if (op == 14) return "R10";
        if (op <= 16) return "R11";
        return "R12";
    endfunction

    task automatic model(input int op, input int d, input int b, input int a, input int f,
                         output int r, output int r2, output int fo);
        int cin, nc, src;
        cin = f % 2;
        r = d; r2 = 0; fo = f; nc = cin;
        src = (op >= 8 && op <= 11) ? a : d;
        case ((op >= 8 && op <= 11) ? op - 4 : op)
            0: begin r = (src * 2) % 256;                 nc = src / 128; end
            1: begin r = src / 2 + (src / 128) * 128;     nc = src % 2;   end
            2: begin r = (src * 2 + 1) % 256;             nc = 0;         end
            3: begin r = src / 2;                         nc = src % 2;   end
            4: begin r = (src * 2 + cin) % 256;           nc = src / 128; end
            5: begin r = src / 2 + cin * 128;             nc = src % 2;   end
            6: begin r = (src * 2 + src / 128) % 256;     nc = src / 128; end
            7: begin r = src / 2 + (src % 2) * 128;       nc = src % 2;   end
            12: begin r = (a / 16) * 16 + d / 16; r2 = (d % 16) * 16 + a % 16; end
            13: begin r = (a / 16) * 16 + d % 16; r2 = (a % 16) * 16 + d / 16; end
            15: r = d | (1 << b);
            16: r = d & (255 - (1 << b));
            default: ;
        endcase
        if (op <= 11) begin
            fo = (fo & ~32'h13) | nc;
            if (op <= 7)
                fo = (fo & ~32'hC4) | ((r / 128) * 128) | ((r == 0) ? 64 : 0) | (par_even(r) * 4);
        end else if (op == 12 || op == 13) begin
            fo = (fo & ~32'hD6) | ((r / 128) * 128) | ((r == 0) ? 64 : 0) | (par_even(r) * 4);
        end else if (op == 14) begin
            fo = (fo & ~32'hC6) | 16 | (((d >> b) % 2 == 0) ? 64 : 0);
        end
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic run(input int op, input int d, input int b, input int a, input int f);
        int r, r2, fo;
        @(posedge clk); #1;
        op_i = 5'(op); opnd_i = 8'(d); bit_sel_i = 3'(b); acc_i = 8'(a); flags_i = 8'(f);
        @(negedge clk);
        model(op, d, b, a, f, r, r2, fo);
        check(rtag(op), "result", int'(res_o), r);
        check(rtag(op), "second result", int'(res2_o), r2);
        check(ftag(op), "flags", int'(flags_o), fo);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !finished) begin
                finished = 1;
                total++; bad++;
                $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        // all-zero inputs: shift left of zero gives Z and even parity (R6)
        @(negedge clk);
        check("R6", "zero-input flags", int'(flags_o), 8'h44);
        check("R1", "zero-input result", int'(res_o), 0);
        check("R12", "zero-input second", int'(res2_o), 0);
        // directed corners
        run(2, 8'hFF, 0, 0, 8'h01);   // R3 one fed in, carry cleared
        run(1, 8'h81, 0, 0, 8'h00);   // R2 sign kept
        run(4, 8'h80, 0, 0, 8'h01);   // R4 carry in and out both one
        run(5, 8'h01, 0, 0, 8'h00);   // R4 zero result from rotate through carry
        run(6, 8'h80, 0, 0, 8'h00);   // R5 wrap
        run(7, 8'h01, 0, 0, 8'h00);   // R5 wrap
        run(8, 8'h00, 0, 8'h80, 8'hC4); // R7 S/Z/PV kept
        run(11, 8'hFF, 0, 8'h01, 8'h28); // R7 spare bits kept
        run(12, 8'h9C, 0, 8'h5E, 8'h01); // R8/R9 distinct nibbles
        run(13, 8'h9C, 0, 8'h5E, 8'h00); // R8/R9
        run(13, 8'h00, 0, 8'h00, 8'h00); // R9 zero new accumulator
        run(14, 8'h80, 7, 0, 8'hFF);  // R10 bit set -> Z clear
        run(14, 8'h7F, 7, 0, 8'h00);  // R10 bit clear -> Z set
        run(15, 8'h00, 7, 0, 8'hA5);  // R11
        run(16, 8'hFF, 0, 0, 8'h5A);  // R11
        run(20, 8'h3C, 2, 8'h11, 8'hFF); // R12 unused code
        for (int op = 0; op < 32; op++) begin
            for (int k = 0; k < 40; k++) begin
                run(op, int'($urandom_range(255)), int'($urandom_range(7)),
                    int'($urandom_range(255)), int'($urandom_range(255)));
            end
        end
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule